// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Bank

This block gathers up to 240 external interrupt lines and presents them to a processor core as one prioritised request. Software programs it through a small word-addressed register space. Each line has an enable bit, a pending bit and an active bit. Software never writes these bits directly. Instead it writes to a set-only window, which turns bits on, or to a clear-only window, which turns bits off. Reading either window returns the current state.

Every line also has a priority byte. Only the upper bits of that byte are stored. A numerically lower value is more urgent. Software can also pend any line by number through a trigger register. The core supplies two controls: a global mask, and a priority threshold that suppresses less urgent lines.

The controller presents the most urgent eligible line as a request with its line number. When the core acknowledges the request, the line moves from pending to active. The line stays active until the core reports completion for that line number.

Top module: `vic_regbank`

## Requirements
- R1: After reset, all enable, pending and active bits are zero and all priority bytes are zero. Every bank reads as zero and `req_valid` is low.
- R2: The enable state is controlled through two windows: a write-one-to-set window at offset 0x100 and a write-one-to-clear window at offset 0x180. Each window has eight words at a 4-byte stride, and bit y of word x maps to line 32x+y. Writing a 0 bit has no effect. Both windows read back the current enable state. Bits for line numbers at or above the line count read as zero.
- R3: The pending state uses the same layout, with its set window at 0x200 and its clear window at 0x280.
- R4: A write to offset 0xE00 makes line `wdata[7:0]` pending. A number at or above the line count is ignored.
- R5: A rising edge on `irq_in[i]` sets pending bit i one cycle later. Holding the line high does not set the bit again after software clears it.
- R6: Priority words start at 0x400. Word x holds line 4x+b in bits [8b+7:8b], for b = 0 to 3. Only the top PRIO_BITS bits of each byte are stored (4 by default), and the lower bits read as zero.
- R7: A line is a candidate when it is both enabled and pending. `req_valid` is high whenever an eligible candidate exists. `req_id` gives the candidate with the lowest priority value, and among equal values the lowest line number wins.
- R8: Only the stored bits of `thresh` are used. When those bits are nonzero, a candidate whose priority value is greater than or equal to the threshold is not requested. A threshold of zero has no effect.
- R9: While `mask_all` is high, no request is made.
- R10: When `ack` is high together with `req_valid`, the requested line loses its pending bit and gains its active bit. When `done` is high, the active bit of line `done_id` clears. The active bank at 0x300 is read-only, so writes to it have no effect.
- R11: If a set source and a clear source hit the same pending or active bit in the same cycle, the set wins. Set sources are a set write, an input edge, a trigger write or an acknowledge. Clear sources are a clear write, an acknowledge or a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_in | input | NUM_IRQ | External interrupt lines |
| mask_all | input | 1 | Global mask: blocks every request |
| thresh | input | 8 | Priority threshold; zero disables the threshold |
| req_valid | output | 1 | A line is being requested |
| req_id | output | 8 | Number of the requested line |
| ack | input | 1 | Core takes the current request |
| done | input | 1 | Core finished a handler |
| done_id | input | 8 | Line whose handler finished |

## Verification
The bench targets several corner cases:
- Priority ties. The bench sets up a tie between two lines of equal priority. An arbiter that compared with less-or-equal would pick the higher-numbered line.
- Threshold. The bench places a threshold exactly at a candidate's priority. An off-by-one compare would let that candidate through.
- Write-zero and clear windows. The bench writes zeros to the set window and reads state back through the clear window. Direct-write logic would wipe state on the zero write, and a read mux that returned zero for the clear window would fail the readback.
- Held input. The bench holds an input line high after software clears its pending bit. A level-sensitive design would re-pend it.
- Set against clear. The bench fires an input edge in the same cycle as a clear write to the same bit. A clear-wins merge would drop that interrupt.
- Boundaries. Out-of-range trigger numbers, bits above the line count, and writes to the active bank are all expected to leave state untouched.

// File: rtl/vic_pkg.sv
package vic_pkg;

  localparam int BANK_WORDS = 8;
  localparam int WORD_W     = 32;
  localparam int ID_W       = 8;

  typedef enum logic [2:0] {
    BK_NONE,
    BK_EN_SET,
    BK_EN_CLR,
    BK_PD_SET,
    BK_PD_CLR,
    BK_ACT,
    BK_PRIO,
    BK_TRIG
  } bank_e;

  // Window decode from the byte offset.
  function automatic bank_e decode_bank(logic [11:0] a);
    bank_e b;
    b = BK_NONE;
    if (a == 12'hE00)                        b = BK_TRIG;
    else if (a[11:8] == 4'h4)                b = BK_PRIO;
    else if (a[11:10] == 2'b00 && a[6:5] == 2'b00) begin
      case (a[9:7])
        3'd2:    b = BK_EN_SET;
        3'd3:    b = BK_EN_CLR;
        3'd4:    b = BK_PD_SET;
        3'd5:    b = BK_PD_CLR;
        3'd6:    b = BK_ACT;
        default: b = BK_NONE;
      endcase
    end
    return b;
  endfunction

  // Mask that keeps the implemented upper bits of a priority byte.
  function automatic logic [7:0] prio_mask(int bits);
    return 8'(((1 << bits) - 1) << (8 - bits));
  endfunction

  // True when a priority value passes the threshold.
  function automatic logic thresh_ok(logic [7:0] p, logic [7:0] t);
    return (t == 8'h00) || (p < t);
  endfunction

endpackage

// File: rtl/vic_lines.sv
module vic_lines #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] en_set,
  input  logic [NUM_IRQ-1:0] en_clr,
  input  logic [NUM_IRQ-1:0] pd_set,
  input  logic [NUM_IRQ-1:0] pd_clr,
  input  logic [NUM_IRQ-1:0] act_set,
  input  logic [NUM_IRQ-1:0] act_clr,
  output logic [NUM_IRQ-1:0] en_q,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic [NUM_IRQ-1:0] act_q,
  output logic [NUM_IRQ-1:0] edge_seen
);

  logic [NUM_IRQ-1:0] irq_prev;

  assign edge_seen = irq_in & ~irq_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_prev <= '0;
      en_q     <= '0;
      pend_q   <= '0;
      act_q    <= '0;
    end else begin
      irq_prev <= irq_in;
      en_q     <= (en_q & ~en_clr) | en_set;
      pend_q   <= (pend_q & ~pd_clr) | pd_set | edge_seen;
      act_q    <= (act_q & ~act_clr) | act_set;
    end
  end

endmodule

// File: rtl/vic_prio_store.sv
module vic_prio_store #(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [5:0]           wr_word,
  input  logic [31:0]          wr_data,
  input  logic [5:0]           rd_word,
  output logic [31:0]          rd_data,
  output logic [NUM_IRQ*8-1:0] prio_flat
);
  import vic_pkg::*;

  localparam int         NPW   = (NUM_IRQ + 3) / 4;
  localparam logic [7:0] PMASK = prio_mask(PRIO_BITS);

  logic [7:0]        prio_q [NUM_IRQ];
  logic [NPW*32-1:0] word_pad;

  for (genvar i = 0; i < NPW * 4; i++) begin : g_line
    if (i < NUM_IRQ) begin : g_real
      always_ff @(posedge clk) begin
        if (!rst_n) prio_q[i] <= 8'h00;
        else if (wr_en && wr_word == 6'(i / 4))
          prio_q[i] <= wr_data[(i % 4) * 8 +: 8] & PMASK;
      end
      assign word_pad[i*8 +: 8]  = prio_q[i];
      assign prio_flat[i*8 +: 8] = prio_q[i];
    end else begin : g_pad
      assign word_pad[i*8 +: 8] = 8'h00;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < NPW; w++)
      if (rd_word == 6'(w)) rd_data = word_pad[w*32 +: 32];
  end

endmodule

// File: rtl/vic_pick.sv
module vic_pick #(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 4
) (
  input  logic [NUM_IRQ-1:0]   cand,
  input  logic [NUM_IRQ*8-1:0] prio_flat,
  input  logic                 mask_all,
  input  logic [7:0]           thresh,
  output logic                 req_valid,
  output logic [7:0]           req_id,
  output logic [7:0]           win_prio
);
  import vic_pkg::*;

  localparam logic [7:0] PMASK = prio_mask(PRIO_BITS);

  logic [7:0] t_eff;
  logic [7:0] p_cur;

  assign t_eff = thresh & PMASK;

  // Linear scan; strict less-than keeps the lowest index on ties.
  always_comb begin
    req_valid = 1'b0;
    req_id    = 8'h00;
    win_prio  = 8'hFF;
    p_cur     = 8'h00;
    for (int i = 0; i < NUM_IRQ; i++) begin
      p_cur = prio_flat[i*8 +: 8];
      if (cand[i] && !mask_all && thresh_ok(p_cur, t_eff) &&
          (!req_valid || p_cur < win_prio)) begin
        req_valid = 1'b1;
        req_id    = 8'(i);
        win_prio  = p_cur;
      end
    end
  end

endmodule

// File: rtl/vic_regbank.sv
module vic_regbank #(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               mask_all,
  input  logic [7:0]         thresh,
  output logic               req_valid,
  output logic [7:0]         req_id,
  input  logic               ack,
  input  logic               done,
  input  logic [7:0]         done_id
);
  import vic_pkg::*;

  localparam int PAD_W = BANK_WORDS * WORD_W;

  bank_e              bank;
  logic [2:0]         bank_word;
  logic [5:0]         prio_word;
  logic [NUM_IRQ-1:0] wr_bits, trig_hot, ack_hot, done_hot;
  logic [NUM_IRQ-1:0] en_set, en_clr, pd_set, pd_clr;
  logic [NUM_IRQ-1:0] en_q, pend_q, act_q, edge_seen;
  logic [NUM_IRQ*8-1:0] prio_flat;
  logic [31:0]        prio_rd;
  logic [7:0]         win_prio;
  logic               take;
  logic [PAD_W-1:0]   en_pad, pend_pad, act_pad;

  assign bank      = decode_bank(bus_addr);
  assign bank_word = bus_addr[4:2];
  assign prio_word = bus_addr[7:2];
  assign take      = ack && req_valid;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_hot
    assign wr_bits[i]  = (bank_word == 3'(i / 32)) && bus_wdata[i % 32];
    assign trig_hot[i] = bus_we && bank == BK_TRIG && bus_wdata[7:0] == 8'(i);
    assign ack_hot[i]  = take && req_id == 8'(i);
    assign done_hot[i] = done && done_id == 8'(i);
  end

  assign en_set = (bus_we && bank == BK_EN_SET) ? wr_bits : '0;
  assign en_clr = (bus_we && bank == BK_EN_CLR) ? wr_bits : '0;
  assign pd_set = ((bus_we && bank == BK_PD_SET) ? wr_bits : '0) | trig_hot;
  assign pd_clr = ((bus_we && bank == BK_PD_CLR) ? wr_bits : '0) | ack_hot;

  vic_lines #(.NUM_IRQ(NUM_IRQ)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .en_set   (en_set),
    .en_clr   (en_clr),
    .pd_set   (pd_set),
    .pd_clr   (pd_clr),
    .act_set  (ack_hot),
    .act_clr  (done_hot),
    .en_q     (en_q),
    .pend_q   (pend_q),
    .act_q    (act_q),
    .edge_seen(edge_seen)
  );

  vic_prio_store #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_prio (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_we && bank == BK_PRIO),
    .wr_word  (prio_word),
    .wr_data  (bus_wdata),
    .rd_word  (prio_word),
    .rd_data  (prio_rd),
    .prio_flat(prio_flat)
  );

  vic_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_pick (
    .cand     (en_q & pend_q),
    .prio_flat(prio_flat),
    .mask_all (mask_all),
    .thresh   (thresh),
    .req_valid(req_valid),
    .req_id   (req_id),
    .win_prio (win_prio)
  );

  assign en_pad   = PAD_W'(en_q);
  assign pend_pad = PAD_W'(pend_q);
  assign act_pad  = PAD_W'(act_q);

  always_comb begin
    unique case (bank)
      BK_EN_SET, BK_EN_CLR: bus_rdata = en_pad[bank_word*32 +: 32];
      BK_PD_SET, BK_PD_CLR: bus_rdata = pend_pad[bank_word*32 +: 32];
      BK_ACT:               bus_rdata = act_pad[bank_word*32 +: 32];
      BK_PRIO:              bus_rdata = prio_rd;
      default:              bus_rdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/vic_regbank_chk.sv
module vic_regbank_chk #(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [11:0]        bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               mask_all,
  input logic [7:0]         thresh,
  input logic               req_valid,
  input logic [7:0]         req_id,
  input logic               ack,
  input logic [NUM_IRQ-1:0] en_q,
  input logic [NUM_IRQ-1:0] pend_q,
  input logic [NUM_IRQ-1:0] act_q,
  input logic [7:0]         win_prio
);
  localparam int         IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [7:0] NUM_ID = 8'(NUM_IRQ);
  localparam logic [7:0] PMASK  = 8'(((1 << PRIO_BITS) - 1) << (8 - PRIO_BITS));

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] trig_idx;
  assign idx      = req_id[IDX_W-1:0];
  assign trig_idx = bus_wdata[IDX_W-1:0];

  assert_req_is_candidate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (en_q[idx] && pend_q[idx]));

  assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_all |-> !req_valid);

  assert_threshold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (thresh & PMASK) != 8'h00) |-> (win_prio < (thresh & PMASK)));

  assert_ack_activates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_valid) |=> act_q[$past(idx)]);

  assert_trigger_pends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 12'hE00 && bus_wdata[7:0] < NUM_ID) |=> pend_q[$past(trig_idx)]);

endmodule

bind vic_regbank vic_regbank_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .mask_all (mask_all),
  .thresh   (thresh),
  .req_valid(req_valid),
  .req_id   (req_id),
  .ack      (ack),
  .en_q     (en_q),
  .pend_q   (pend_q),
  .act_q    (act_q),
  .win_prio (win_prio)
);

// File: tb/vic_regbank_bench.sv
module vic_regbank_bench;

  localparam int NUM_IRQ = 32;
  localparam int NVEC    = 11;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               bus_we = 1'b0;
  logic [11:0]        bus_addr = 12'h0;
  logic [31:0]        bus_wdata = 32'h0;
  logic [31:0]        bus_rdata;
  logic [NUM_IRQ-1:0] irq_in = '0;
  logic               mask_all = 1'b0;
  logic [7:0]         thresh = 8'h00;
  logic               req_valid;
  logic [7:0]         req_id;
  logic               ack = 1'b0;
  logic               done = 1'b0;
  logic [7:0]         done_id = 8'h00;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vic_regbank #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(4)) u_vic_regbank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .mask_all(mask_all), .thresh(thresh), .req_valid(req_valid),
    .req_id(req_id), .ack(ack), .done(done), .done_id(done_id)
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [87:0] VECS [NVEC] = '{
    {12'h100, 32'h0000_00F0, 12'h100, 32'h0000_00F0},  // R2 set
    {12'h180, 32'h0000_0030, 12'h100, 32'h0000_00C0},  // R2 clear
    {12'h100, 32'h0000_0000, 12'h180, 32'h0000_00C0},  // R2 zero write, clear window read
    {12'h200, 32'h0000_0F00, 12'h280, 32'h0000_0F00},  // R3 set
    {12'h280, 32'h0000_0300, 12'h200, 32'h0000_0C00},  // R3 clear
    {12'h400, 32'h1234_5678, 12'h400, 32'h1030_5070},  // R6 low bits dropped
    {12'h41C, 32'hFFFF_FFFF, 12'h41C, 32'hF0F0_F0F0},  // R6 last word
    {12'h300, 32'h0000_FFFF, 12'h300, 32'h0000_0000},  // R10 read-only
    {12'hE00, 32'h0000_0005, 12'h200, 32'h0000_0C20},  // R4 trigger line 5
    {12'hE00, 32'h0000_0040, 12'h200, 32'h0000_0C20},  // R4 out of range
    {12'h104, 32'hFFFF_FFFF, 12'h104, 32'h0000_0000}   // R2 beyond line count
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(string tag, logic [11:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic req_check(string tag, logic v, logic [7:0] id);
    #1;
    check({tag, " valid"}, 32'(req_valid), 32'(v));
    if (v) check({tag, " id"}, 32'(req_id), 32'(id));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_check("R1 enable", 12'h100, 32'h0);
    rd_check("R1 pending", 12'h200, 32'h0);
    rd_check("R1 active", 12'h300, 32'h0);
    rd_check("R1 priority", 12'h400, 32'h0);
    req_check("R1 request", 1'b0, 8'h0);

    for (int v = 0; v < NVEC; v++) begin
      wr(VECS[v][87:76], VECS[v][75:44]);
      rd_check($sformatf("vector %0d (R2 R3 R4 R6 R10)", v), VECS[v][43:32], VECS[v][31:0]);
    end
    req_check("R7 no overlap", 1'b0, 8'h0);

    wr(12'h180, 32'hFFFF_FFFF);
    wr(12'h280, 32'hFFFF_FFFF);
    wr(12'h400, 32'h0);
    wr(12'h41C, 32'h0);

    // R7 arbitration: line 3 prio 0x40, lines 9 and 20 prio 0x20
    wr(12'h400, 32'h4000_0000);
    wr(12'h408, 32'h0000_2000);
    wr(12'h414, 32'h0000_0020);
    wr(12'h100, 32'h0010_0208);
    wr(12'h200, 32'h0010_0208);
    req_check("R7 tie lowest index", 1'b1, 8'd9);
    wr(12'h414, 32'h0000_0010);
    req_check("R7 lower value wins", 1'b1, 8'd20);
    wr(12'h414, 32'h0000_0020);
    req_check("R7 restored", 1'b1, 8'd9);

    // R8 threshold
    @(negedge clk); thresh = 8'h20;
    req_check("R8 equal blocked", 1'b0, 8'h0);
    @(negedge clk); thresh = 8'h3F;
    req_check("R8 above passes", 1'b1, 8'd9);
    @(negedge clk); thresh = 8'h0F;
    req_check("R8 low bits only", 1'b1, 8'd9);
    @(negedge clk); thresh = 8'h00;

    // R9 global mask
    mask_all = 1'b1;
    req_check("R9 masked", 1'b0, 8'h0);
    @(negedge clk); mask_all = 1'b0;
    req_check("R9 unmasked", 1'b1, 8'd9);

    // R10 acknowledge and completion
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    rd_check("R10 active after ack", 12'h300, 32'h0000_0200);
    rd_check("R10 pending after ack", 12'h200, 32'h0010_0008);
    req_check("R10 next request", 1'b1, 8'd20);
    @(negedge clk); done = 1'b1; done_id = 8'd9;
    @(negedge clk); done = 1'b0;
    rd_check("R10 active after done", 12'h300, 32'h0);

    wr(12'h180, 32'hFFFF_FFFF);
    wr(12'h280, 32'hFFFF_FFFF);

    // R5 edge detection
    @(negedge clk); irq_in[12] = 1'b1;
    @(negedge clk);
    rd_check("R5 edge pends", 12'h200, 32'h0000_1000);
    wr(12'h280, 32'h0000_1000);
    repeat (3) @(negedge clk);
    rd_check("R5 held high no repend", 12'h200, 32'h0);

    // R11 set beats clear in the same cycle
    irq_in[12] = 1'b0;
    @(negedge clk);
    irq_in[12] = 1'b1;
    bus_we = 1'b1; bus_addr = 12'h280; bus_wdata = 32'h0000_1000;
    @(negedge clk);
    bus_we = 1'b0;
    rd_check("R11 set wins", 12'h200, 32'h0000_1000);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule